// File: doc/BRIEF.md
# Two-Bank Legacy Interrupt Controller

This block gathers interrupt line changes from ordinary devices and from DMA channels and records them in two banks of registers. Each bank holds a mask, a set of latched events and the current line levels. Every source reports a one-hot identifier together with the present state of its line. The identifier's position decides the bank: high positions are shifted down into bank 2, low positions go to bank 1 as they are. Software programs the masks and acknowledges events through a one-word register write port. Each written word arrives byte-swapped, so it is byte-reversed before use. A single interrupt request to the processor follows the pending events.

Only the legacy emulation mode is built. Bit 31 of mask 1 is the mode bit, and line changes are recorded only while it is set. The write port and both source ports have a valid strobe and no ready signal. They accept a transfer on every cycle, so there is no back-pressure. One register write, one device change and one DMA change can all arrive in the same cycle. The six bank registers are presented on output ports so that they can be observed.

Top module: `icb_top`

## Requirements
- R1: Every written word is byte-reversed before use (byte 0 is exchanged with byte 3 and byte 1 with byte 2). The bit positions below refer to the reversed word.
- R2: A write with select 0 loads mask 1 with the whole word and copies its bit 31 into bit 31 of mask 2.
- R3: A write with select 2 ORs bits 30:0 of the word into mask 2. Bit 31 of mask 2 is left as it was.
- R4: A write with select 3 clears each event-2 bit among 30:0 that is set in the word. The interrupt request is low on the next cycle when no line change arrives in the same cycle.
- R5: A write with select 1 zeroes both event registers when mask 1 bit 31 and word bit 31 are both set. Otherwise it clears each event-1 bit among 30:0 that is set in the word. Either way the interrupt request is low next cycle when no line change arrives in the same cycle.
- R6: A device change whose identifier is at bit 20 or above goes to bank 2, shifted right by 10. A lower identifier goes to bank 1 unshifted.
- R7: A DMA change whose identifier is at bit 10 or above goes to bank 2, shifted right by 10. A lower identifier goes to bank 1 unshifted.
- R8: The identifier bit is ORed into the target bank's event register, and that register is then ANDed with its mask. The mask used is the one in effect after any write in the same cycle. The other bank's events are not changed by the line change.
- R9: The level bit for the identifier is set when the reported line is high and cleared when it is low. When both sources hit the same level bit in one cycle, the DMA value is the one kept.
- R10: After a cycle with an accepted line change, the interrupt request is high exactly when event 1 or event 2 has a bit set among 30:0. When there is neither a line change nor a clear write, the request holds its value.
- R11: While mask 1 bit 31 is clear, line changes are ignored: the events, the levels and the request do not change.
- R12: A clear write and a line change in the same cycle apply the clear first, so the new event survives.
- R13: Reset zeroes all six registers and the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 mask 1, 1 clear 1, 2 mask 2, 3 clear 2 |
| wr_data | input | 32 | Write word, byte-swapped order |
| dev_valid | input | 1 | Device line change strobe |
| dev_id | input | 32 | One-hot device identifier |
| dev_level | input | 1 | New device line state |
| dma_valid | input | 1 | DMA line change strobe |
| dma_id | input | 32 | One-hot DMA identifier |
| dma_level | input | 1 | New DMA line state |
| irq_out | output | 1 | Interrupt request to the processor |
| mask1_o | output | 32 | Mask 1 |
| mask2_o | output | 32 | Mask 2 |
| event1_o | output | 32 | Event 1 |
| event2_o | output | 32 | Event 2 |
| level1_o | output | 32 | Level 1 |
| level2_o | output | 32 | Level 2 |

## Verification
Some rules hold on every cycle, and the assertions check those. Mask 2 never loses a bit through its own write. Bit 31 of mask 1 is copied into mask 2. A clear only removes event bits. The request falls after a clear write and otherwise holds. Bit 31 of either event register is never set. The bank routing thresholds and the shift amounts can only be shown by the scenarios. The same goes for the byte reversal, the rule that DMA wins on a shared level bit, and the clear-before-event ordering. For these the bench sweeps every one-hot identifier on both sources and compares every register against arithmetic it computes itself.

// File: rtl/icb_pkg.sv
package icb_pkg;
  typedef enum logic [1:0] {
    SEL_MASK1  = 2'd0,
    SEL_CLEAR1 = 2'd1,
    SEL_MASK2  = 2'd2,
    SEL_CLEAR2 = 2'd3
  } icb_sel_e;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/icb_route.sv
module icb_route #(
  parameter int DW    = 32,
  parameter int SPLIT = 20,
  parameter int SHIFT = 10
) (
  input  logic          en,
  input  logic [DW-1:0] id,
  output logic [DW-1:0] to_b1,
  output logic [DW-1:0] to_b2
);
  localparam logic [DW-1:0] LIMIT = DW'(1) << SPLIT;

  logic upper;
  assign upper = (id >= LIMIT);

  always_comb begin
    to_b1 = '0;
    to_b2 = '0;
    if (en) begin
      if (upper) to_b2 = id >> SHIFT;
      else       to_b1 = id;
    end
  end
endmodule

// File: rtl/icb_bank.sv
module icb_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic [DW-1:0] clr_bits,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] hit_a,
  input  logic          lvl_a,
  input  logic [DW-1:0] hit_b,
  input  logic          lvl_b,
  output logic [DW-1:0] ev_next,
  output logic [DW-1:0] ev_q,
  output logic [DW-1:0] lev_q
);
  logic [DW-1:0] ev_clr;
  logic [DW-1:0] hit_any;
  logic [DW-1:0] lev_a_n;
  logic [DW-1:0] lev_next;

  assign hit_any = hit_a | hit_b;

  always_comb begin
    ev_clr  = clr_all ? '0 : (ev_q & ~clr_bits);
    ev_next = (|hit_any) ? ((ev_clr | hit_any) & mask) : ev_clr;
  end

  always_comb begin
    lev_a_n  = lvl_a ? (lev_q | hit_a) : (lev_q & ~hit_a);
    lev_next = lvl_b ? (lev_a_n | hit_b) : (lev_a_n & ~hit_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= '0;
      lev_q <= '0;
    end else begin
      ev_q  <= ev_next;
      lev_q <= lev_next;
    end
  end
endmodule

// File: rtl/icb_top.sv
module icb_top #(
  parameter int DW        = 32,
  parameter int DEV_SPLIT = 20,
  parameter int DMA_SPLIT = 10,
  parameter int B2_SHIFT  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          dev_valid,
  input  logic [DW-1:0] dev_id,
  input  logic          dev_level,
  input  logic          dma_valid,
  input  logic [DW-1:0] dma_id,
  input  logic          dma_level,
  output logic          irq_out,
  output logic [DW-1:0] mask1_o,
  output logic [DW-1:0] mask2_o,
  output logic [DW-1:0] event1_o,
  output logic [DW-1:0] event2_o,
  output logic [DW-1:0] level1_o,
  output logic [DW-1:0] level2_o
);
  import icb_pkg::*;

  localparam int NBYTES   = DW / 8;
  localparam int MODE_BIT = DW - 1;
  localparam logic [DW-1:0] LOW_BITS = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] wr_sw;
  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_swap
      assign wr_sw[gi*8 +: 8] = wr_data[(NBYTES-1-gi)*8 +: 8];
    end
  endgenerate

  icb_sel_e sel;
  assign sel = icb_sel_e'(wr_sel);

  logic [DW-1:0] mask1_q, mask2_q, mask1_n, mask2_n;
  logic          mode;
  assign mode = mask1_q[MODE_BIT];

  always_comb begin
    mask1_n = mask1_q;
    mask2_n = mask2_q;
    if (wr_valid) begin
      if (sel == SEL_MASK1) begin
        mask1_n = wr_sw;
        mask2_n[MODE_BIT] = wr_sw[MODE_BIT];
      end else if (sel == SEL_MASK2) begin
        mask2_n = mask2_q | (wr_sw & LOW_BITS);
      end
    end
  end

  logic          clr1_wr, clr2_wr, wipe_all;
  logic [DW-1:0] clr_bits [icb_pkg::NUM_BANKS];
  logic          clr_all  [icb_pkg::NUM_BANKS];

  assign clr1_wr  = wr_valid && (sel == SEL_CLEAR1);
  assign clr2_wr  = wr_valid && (sel == SEL_CLEAR2);
  assign wipe_all = clr1_wr && mode && wr_sw[MODE_BIT];

  assign clr_all[0]  = wipe_all;
  assign clr_all[1]  = wipe_all;
  assign clr_bits[0] = (clr1_wr && !wipe_all) ? (wr_sw & LOW_BITS) : '0;
  assign clr_bits[1] = clr2_wr ? (wr_sw & LOW_BITS) : '0;

  logic dev_en, dma_en, line_any;
  assign dev_en   = dev_valid && mode;
  assign dma_en   = dma_valid && mode;
  assign line_any = dev_en || dma_en;

  logic [DW-1:0] dev_hit [icb_pkg::NUM_BANKS];
  logic [DW-1:0] dma_hit [icb_pkg::NUM_BANKS];

  icb_route #(.DW(DW), .SPLIT(DEV_SPLIT), .SHIFT(B2_SHIFT)) u_dev_route (
    .en(dev_en), .id(dev_id), .to_b1(dev_hit[0]), .to_b2(dev_hit[1])
  );
  icb_route #(.DW(DW), .SPLIT(DMA_SPLIT), .SHIFT(B2_SHIFT)) u_dma_route (
    .en(dma_en), .id(dma_id), .to_b1(dma_hit[0]), .to_b2(dma_hit[1])
  );

  logic [DW-1:0] bank_mask [icb_pkg::NUM_BANKS];
  logic [DW-1:0] ev_next   [icb_pkg::NUM_BANKS];
  logic [DW-1:0] ev_q      [icb_pkg::NUM_BANKS];
  logic [DW-1:0] lev_q     [icb_pkg::NUM_BANKS];

  assign bank_mask[0] = mask1_n;
  assign bank_mask[1] = mask2_n;

  generate
    for (gi = 0; gi < icb_pkg::NUM_BANKS; gi++) begin : g_bank
      icb_bank #(.DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .clr_all(clr_all[gi]), .clr_bits(clr_bits[gi]),
        .mask(bank_mask[gi]),
        .hit_a(dev_hit[gi]), .lvl_a(dev_level),
        .hit_b(dma_hit[gi]), .lvl_b(dma_level),
        .ev_next(ev_next[gi]), .ev_q(ev_q[gi]), .lev_q(lev_q[gi])
      );
    end
  endgenerate

  logic irq_q, irq_n;
  always_comb begin
    irq_n = irq_q;
    if (line_any)              irq_n = |((ev_next[0] | ev_next[1]) & LOW_BITS);
    else if (clr1_wr || clr2_wr) irq_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask1_q <= '0;
      mask2_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      mask1_q <= mask1_n;
      mask2_q <= mask2_n;
      irq_q   <= irq_n;
    end
  end

  assign irq_out  = irq_q;
  assign mask1_o  = mask1_q;
  assign mask2_o  = mask2_q;
  assign event1_o = ev_q[0];
  assign event2_o = ev_q[1];
  assign level1_o = lev_q[0];
  assign level2_o = lev_q[1];
endmodule

// File: rtl/icb_checker.sv
module icb_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [1:0]    wr_sel,
  input logic          dev_valid,
  input logic          dma_valid,
  input logic          irq_out,
  input logic [DW-1:0] mask1_o,
  input logic [DW-1:0] mask2_o,
  input logic [DW-1:0] event1_o,
  input logic [DW-1:0] event2_o
);
  logic is_clear, no_line;
  assign is_clear = wr_valid && (wr_sel == 2'd1 || wr_sel == 2'd3);
  assign no_line  = !dev_valid && !dma_valid;

  // R3
  mask2_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel == 2'd2) |=> (($past(mask2_o) & ~mask2_o) == '0));

  // R2
  mode_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel == 2'd0) |=> (mask2_o[DW-1] == mask1_o[DW-1]));

  // R4
  clear2_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel == 2'd3 && no_line) |=> ((event2_o & ~$past(event2_o)) == '0));

  // R5
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_clear && no_line) |=> !irq_out);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && no_line) |=> $stable(irq_out));

  // R8
  top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !event1_o[DW-1] && !event2_o[DW-1]);
endmodule

bind icb_top icb_checker #(.DW(DW)) u_icb_checker (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
  .dev_valid(dev_valid), .dma_valid(dma_valid), .irq_out(irq_out),
  .mask1_o(mask1_o), .mask2_o(mask2_o), .event1_o(event1_o), .event2_o(event2_o)
);

// File: tb/test_icb_top.sv
module test_icb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        dev_valid = 1'b0;
  logic [31:0] dev_id = '0;
  logic        dev_level = 1'b0;
  logic        dma_valid = 1'b0;
  logic [31:0] dma_id = '0;
  logic        dma_level = 1'b0;
  logic        irq_out;
  logic [31:0] mask1_o, mask2_o, event1_o, event2_o, level1_o, level2_o;

  always #4 clk = ~clk;

  icb_top i_icb_top (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
    .dev_valid(dev_valid), .dev_id(dev_id), .dev_level(dev_level),
    .dma_valid(dma_valid), .dma_id(dma_id), .dma_level(dma_level),
    .irq_out(irq_out), .mask1_o(mask1_o), .mask2_o(mask2_o),
    .event1_o(event1_o), .event2_o(event2_o), .level1_o(level1_o), .level2_o(level2_o)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] m1 = '0, m2 = '0, e1 = '0, e2 = '0, l1 = '0, l2 = '0;
  logic        irq_m = 1'b0;
  localparam logic [31:0] LOW = 32'h7FFF_FFFF;

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "irq", {31'd0, irq_out}, {31'd0, irq_m});
    chk(tag, "mask1", mask1_o, m1);
    chk(tag, "mask2", mask2_o, m2);
    chk(tag, "event1", event1_o, e1);
    chk(tag, "event2", event2_o, e2);
    chk(tag, "level1", level1_o, l1);
    chk(tag, "level2", level2_o, l2);
  endtask

  // Bench model built from the requirements.
  task automatic model(input logic wv, input logic [1:0] sel, input logic [31:0] wd,
                       input logic dv, input logic [31:0] did, input logic dl,
                       input logic mv, input logic [31:0] mid, input logic ml);
    logic [31:0] sw, h1, h2, dh1, dh2, mh1, mh2;
    logic mode, line;
    sw = bswap(wd);
    mode = m1[31];
    if (wv) begin
      case (sel)
        2'd0: begin m1 = sw; m2[31] = sw[31]; end
        2'd2: m2 = m2 | (sw & LOW);
        2'd1: if (mode && sw[31]) begin e1 = '0; e2 = '0; end else e1 = e1 & ~(sw & LOW);
        default: e2 = e2 & ~(sw & LOW);
      endcase
    end
    dh1 = '0; dh2 = '0; mh1 = '0; mh2 = '0;
    if (mode && dv) begin
      if (did >= 32'h0010_0000) dh2 = did >> 10; else dh1 = did;
    end
    if (mode && mv) begin
      if (mid >= 32'h0000_0400) mh2 = mid >> 10; else mh1 = mid;
    end
    l1 = dl ? (l1 | dh1) : (l1 & ~dh1);
    l2 = dl ? (l2 | dh2) : (l2 & ~dh2);
    l1 = ml ? (l1 | mh1) : (l1 & ~mh1);
    l2 = ml ? (l2 | mh2) : (l2 & ~mh2);
    h1 = dh1 | mh1;
    h2 = dh2 | mh2;
    if (h1 != 0) e1 = (e1 | h1) & m1;
    if (h2 != 0) e2 = (e2 | h2) & m2;
    line = mode && (dv || mv);
    if (line) irq_m = |((e1 | e2) & LOW);
    else if (wv && (sel == 2'd1 || sel == 2'd3)) irq_m = 1'b0;
  endtask

  task automatic step(input string tag, input logic wv, input logic [1:0] sel, input logic [31:0] wd,
                      input logic dv, input logic [31:0] did, input logic dl,
                      input logic mv, input logic [31:0] mid, input logic ml);
    wr_valid = wv; wr_sel = sel; wr_data = wd;
    dev_valid = dv; dev_id = did; dev_level = dl;
    dma_valid = mv; dma_id = mid; dma_level = ml;
    model(wv, sel, wd, dv, did, dl, mv, mid, ml);
    @(posedge clk);
    #1;
    wr_valid = 1'b0; dev_valid = 1'b0; dma_valid = 1'b0;
    check_all(tag);
  endtask

  task automatic wr(input string tag, input logic [1:0] sel, input logic [31:0] raw);
    step(tag, 1'b1, sel, raw, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic dev(input string tag, input logic [31:0] id, input logic lv);
    step(tag, 1'b0, 2'd0, '0, 1'b1, id, lv, 1'b0, '0, 1'b0);
  endtask

  task automatic dma(input string tag, input logic [31:0] id, input logic lv);
    step(tag, 1'b0, 2'd0, '0, 1'b0, '0, 1'b0, 1'b1, id, lv);
  endtask

  logic done = 1'b0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #20;
    check_all("R13");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 R2: byte order and mode copy; R3: mask 2 OR-in
    wr("R1", 2'd0, bswap(32'h8000_0000 | 32'h0012_3456));
    wr("R2", 2'd0, bswap(32'hFFFF_FFFF));
    wr("R3", 2'd2, bswap(32'h0000_F0F0));
    wr("R3", 2'd2, bswap(32'hFFFF_FFFF));
    wr("R3", 2'd2, bswap(32'h0000_0001));

    // R6: sweep every device identifier, high then low
    for (int i = 0; i < 32; i++) begin
      dev("R6", 32'd1 << i, 1'b1);
      dev("R9", 32'd1 << i, 1'b0);
    end
    wr("R5", 2'd1, bswap(32'h8000_0000));
    // R7: sweep every DMA identifier
    for (int i = 0; i < 32; i++) begin
      dma("R7", 32'd1 << i, 1'b1);
      if (i % 3 == 0) dma("R9", 32'd1 << i, 1'b0);
    end
    // R4: partial clears of bank 2, R5 partial clear of bank 1
    wr("R4", 2'd3, bswap(32'h0000_0F0F));
    wr("R4", 2'd3, bswap(32'h7FFF_FFFF));
    for (int i = 0; i < 10; i++) dma("R10", 32'd1 << i, 1'b1);
    wr("R5", 2'd1, bswap(32'h0000_00FF));
    wr("R5", 2'd1, bswap(32'h0000_0300));
    dev("R10", 32'd1 << 3, 1'b1);
    // R12: clear and event together
    step("R12", 1'b1, 2'd1, bswap(32'h8000_0000), 1'b1, 32'd1 << 5, 1'b1, 1'b0, '0, 1'b0);
    step("R12", 1'b1, 2'd3, bswap(32'h7FFF_FFFF), 1'b0, '0, 1'b0, 1'b1, 32'd1 << 12, 1'b1);
    // R9: both sources hit the same level bit, DMA wins
    step("R9", 1'b0, 2'd0, '0, 1'b1, 32'd1 << 4, 1'b1, 1'b1, 32'd1 << 4, 1'b0);
    step("R9", 1'b0, 2'd0, '0, 1'b1, 32'd1 << 4, 1'b0, 1'b1, 32'd1 << 4, 1'b1);
    // R8: events limited by mask, mask written in the same cycle
    wr("R8", 2'd0, bswap(32'h8000_000F));
    for (int i = 0; i < 8; i++) dev("R8", 32'd1 << i, 1'b1);
    step("R8", 1'b1, 2'd0, bswap(32'h8000_00F0), 1'b1, 32'd1 << 6, 1'b1, 1'b0, '0, 1'b0);
    // R11: mode off, changes ignored and clear-all bit not honoured
    wr("R11", 2'd0, bswap(32'h0000_FFFF));
    for (int i = 0; i < 32; i += 4) begin
      dev("R11", 32'd1 << i, 1'b1);
      dma("R11", 32'd1 << i, 1'b0);
    end
    wr("R5", 2'd1, bswap(32'h8000_0010));
    wr("R2", 2'd0, bswap(32'h8000_FFFF));
    dev("R10", 32'd1 << 25, 1'b1);
    wr("R5", 2'd1, bswap(32'h8000_0000));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule